// File: doc/BRIEF.md
# Serial Line Receiver with Break Detection

This block turns an asynchronous serial input into characters. A baud tick that pulses sixteen times per bit period drives it. It finds a start edge and confirms it at the middle of the start bit. It then samples each data bit, the optional parity bit and the first stop bit once, at the centre of the bit. The character goes into a small receive queue together with its own status: parity error, framing error and break. A sticky overrun flag reports characters that were lost because the queue was full.

The frame format comes from a six-bit line-control word that is shared with the transmitter. The consumer watches `rx_ready` and reads the oldest character and its flags from `rx_data` and the `err_*` outputs. It pulses `rd_en` for one clock to remove that character, and the same pulse acknowledges the overrun flag.

The frame engine is a state machine with six states:

- **IDLE**: waits for a tick with the line low, then goes to **START**.
- **START**: counts to the middle of the start bit. It goes to **DATA** if the line is still low there, and back to **IDLE** if it is not.
- **DATA**: takes one sample per bit period. After the last data bit it goes to **PARITY** when parity is enabled, and to **STOP** otherwise.
- **PARITY**: takes one sample, then goes to **STOP**.
- **STOP**: samples the stop bit and writes the character to the queue. It then goes to **BRK_WAIT** if the character is a break, and to **IDLE** otherwise.
- **BRK_WAIT**: stays until the line is high, then goes to **IDLE**.

Top module: `uart_rx_break`

## Requirements
- R1: `line_ctl[1:0]` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits are assembled least significant first, and unused upper bits of `rx_data` read 0.
- R2: A low level on `rxd` is accepted as a start bit only if it is still low at the eighth baud tick after it was detected. A shorter low pulse produces no character.
- R3: Each data bit is sampled once, sixteen ticks after the previous sample, so that every sample falls near the centre of its bit.
- R4: `line_ctl[3]` enables a parity bit after the data bits. `line_ctl[5:4]` selects the parity mode: 00 odd, 01 even, 10 always 1, 11 always 0. A received parity bit that does not match sets `err_parity` for that character.
- R5: `line_ctl[2]`, the stop-length select, has no effect on reception. Only the first stop bit is checked.
- R6: A stop bit sampled low sets `err_frame` for that character, unless the frame is a break.
- R7: A frame whose data, parity and stop samples are all 0 is stored with `err_break`=1, `rx_data`=0, `err_frame`=0 and `err_parity`=0. No new start bit is looked for until `rxd` has returned high.
- R8: The queue holds 16 characters. `rx_ready` is high while it is non-empty, and `rx_data` and the `err_parity`, `err_frame` and `err_break` outputs show the oldest entry. A `rd_en` cycle removes that entry.
- R9: A frame that completes while the queue is full, with no read in that cycle, is discarded and sets `err_overrun`. `err_overrun` clears after any cycle in which `rd_en` is high.
- R10: A frame that completes in the same cycle as a read of a full queue is stored, and `err_overrun` stays 0.
- R11: After reset the queue is empty, `rx_ready` is 0 and all error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxd | input | 1 | Serial input line, idle high |
| baud_tick | input | 1 | One-clock pulse, 16 per bit period |
| line_ctl | input | 6 | Frame format: length, stop select, parity enable, parity mode |
| rd_en | input | 1 | Removes the oldest character and clears overrun |
| rx_data | output | 8 | Oldest received character |
| rx_ready | output | 1 | Queue holds at least one character |
| err_parity | output | 1 | Parity error of the oldest character |
| err_frame | output | 1 | Framing error of the oldest character |
| err_break | output | 1 | Oldest character is a break |
| err_overrun | output | 1 | A character was lost because the queue was full |

## Verification
A completed frame can be written into the queue in the same clock in which the consumer removes an entry from a full queue. The handling of that clock decides between a clean shift and a spurious overrun. The bench fills the queue with sixteen frames. It then counts baud ticks from the falling start edge of a seventeenth frame and places a single `rd_en` pulse exactly on the stop-sample tick. The case is judged correct if `err_overrun` stays 0 and the sixteen entries read out afterwards are the second through the seventeenth characters, in order.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_BRK_WAIT
    } rx_state_t;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_mode_t;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       baud_tick,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic [1:0] par_sel,
    output logic       push,
    output rx_char_t   char_o
);
    localparam int unsigned CNTW = $clog2(OSR);
    localparam logic [CNTW-1:0] MID_CNT  = CNTW'(OSR / 2 - 1);
    localparam logic [CNTW-1:0] LAST_CNT = CNTW'(OSR - 1);

    rx_state_t       state_q, state_d;
    logic [CNTW-1:0] tick_cnt;
    logic [2:0]      bit_idx;
    logic [7:0]      data_q;
    logic            par_q;
    logic            start_mid, bit_mid, last_bit, is_break, par_exp;
    par_mode_t       par_mode;

    assign par_mode  = par_mode_t'(par_sel);
    assign start_mid = baud_tick && (tick_cnt == MID_CNT);
    assign bit_mid   = baud_tick && (tick_cnt == LAST_CNT);
    assign last_bit  = (bit_idx == (3'd4 + {1'b0, len_sel}));
    assign is_break  = !rxd && (data_q == 8'h00) && !(par_en && par_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:     if (baud_tick && !rxd) state_d = RX_START;
            RX_START:    if (start_mid) state_d = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:     if (bit_mid && last_bit) state_d = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY:   if (bit_mid) state_d = RX_STOP;
            RX_STOP:     if (bit_mid) state_d = is_break ? RX_BRK_WAIT : RX_IDLE;
            RX_BRK_WAIT: if (rxd) state_d = RX_IDLE;
            default:     state_d = RX_IDLE;
        endcase
    end

    // sample counters and shift data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            data_q   <= '0;
            par_q    <= 1'b0;
        end else begin
            if (state_q == RX_IDLE || state_q == RX_BRK_WAIT) begin
                tick_cnt <= '0;
                bit_idx  <= '0;
                data_q   <= '0;
                par_q    <= 1'b0;
            end else if (baud_tick) begin
                tick_cnt <= (state_q == RX_START && start_mid) ? '0 : tick_cnt + 1'b1;
                if (state_q == RX_DATA && bit_mid) begin
                    data_q[bit_idx] <= rxd;
                    bit_idx         <= bit_idx + 3'd1;
                end
                if (state_q == RX_PARITY && bit_mid) par_q <= rxd;
            end
        end
    end

    // expected parity bit for the selected mode
    always_comb begin
        unique case (par_mode)
            PAR_ODD:   par_exp = ~^data_q;
            PAR_EVEN:  par_exp = ^data_q;
            PAR_MARK:  par_exp = 1'b1;
            PAR_SPACE: par_exp = 1'b0;
            default:   par_exp = 1'b0;
        endcase
    end

    // outputs
    always_comb begin
        push        = (state_q == RX_STOP) && bit_mid;
        char_o.data = data_q;
        char_o.brk  = is_break;
        char_o.frm  = !rxd && !is_break;
        char_o.par  = par_en && (par_q != par_exp) && !is_break;
    end

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_char_t                   wdata,
    input  logic                       rd_en,
    output rx_char_t                   rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       pop
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    rx_char_t      mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          wr_ok;

    assign full  = (count == CNT_FULL);
    assign pop   = rd_en && (count != '0);
    assign wr_ok = push && (!full || pop);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)   rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (wr_ok && !pop)      count <= count + 1'b1;
            else if (pop && !wr_ok) count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned OSR   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       baud_tick,
    input  logic [5:0] line_ctl,
    input  logic       rd_en,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_break,
    output logic       err_overrun
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    rx_char_t        frame_char, head;
    logic            frame_push, fifo_full, pop_fire, ovr_q;
    logic [CW-1:0]   fifo_count;
    logic            unused_stop_sel;

    assign unused_stop_sel = line_ctl[2];

    uart_rx_frame #(.OSR(OSR)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .baud_tick (baud_tick),
        .len_sel   (line_ctl[1:0]),
        .par_en    (line_ctl[3]),
        .par_sel   (line_ctl[5:4]),
        .push      (frame_push),
        .char_o    (frame_char)
    );

    rx_char_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (frame_push),
        .wdata (frame_char),
        .rd_en (rd_en),
        .rdata (head),
        .count (fifo_count),
        .full  (fifo_full),
        .pop   (pop_fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               ovr_q <= 1'b0;
        else if (frame_push && fifo_full && !pop_fire) ovr_q <= 1'b1;
        else if (rd_en)                           ovr_q <= 1'b0;
    end

    assign rx_ready    = (fifo_count != '0);
    assign rx_data     = rx_ready ? head.data : 8'h00;
    assign err_parity  = rx_ready && head.par;
    assign err_frame   = rx_ready && head.frm;
    assign err_break   = rx_ready && head.brk;
    assign err_overrun = ovr_q;

endmodule

// File: rtl/uart_rx_break_chk.sv
module uart_rx_break_chk #(
    parameter int unsigned DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rd_en,
    input logic                       rx_ready,
    input logic [7:0]                 rx_data,
    input logic                       err_parity,
    input logic                       err_frame,
    input logic                       err_break,
    input logic                       err_overrun,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count,
    input logic                       push_req,
    input logic                       pop_fire
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    AST_BREAK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && err_break) |-> (!err_frame && !err_parity && rx_data == 8'h00)); // R7

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH)); // R8

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && fifo_count == CW'(DEPTH) && !rd_en) |=> err_overrun); // R9

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !err_overrun); // R9

    AST_SIMUL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_fire) |=> $stable(fifo_count)); // R10

    AST_NO_FALSE_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_fire && !err_overrun) |=> !err_overrun); // R10

endmodule

bind uart_rx_break uart_rx_break_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_break   (err_break),
    .err_overrun (err_overrun),
    .fifo_count  (fifo_count),
    .push_req    (frame_push),
    .pop_fire    (pop_fire)
);

// File: tb/uart_rx_break_bench.sv
`timescale 1ns/1ps
module uart_rx_break_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       baud_tick = 1'b0;
    logic [5:0] line_ctl = 6'b000011;
    logic       rd_en = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_parity, err_frame, err_break, err_overrun;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    uart_rx_break u_uart_rx_break (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
        .line_ctl(line_ctl), .rd_en(rd_en), .rx_data(rx_data),
        .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
        .err_break(err_break), .err_overrun(err_overrun)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            do @(posedge clk); while (baud_tick !== 1'b1);
        end
    endtask

    function automatic logic calc_par(input logic [1:0] mode, input logic [7:0] d);
        case (mode)
            2'b00:   return ~^d;
            2'b01:   return ^d;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_frame(input logic [7:0] d, input int nbits, input bit pe, input bit pbit, input bit stopv);
        wait_ticks(1);
        @(negedge clk) rxd = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk) rxd = d[i];
            wait_ticks(16);
        end
        if (pe) begin
            @(negedge clk) rxd = pbit;
            wait_ticks(16);
        end
        @(negedge clk) rxd = stopv;
        wait_ticks(16);
        @(negedge clk) rxd = 1'b1;
        wait_ticks(32);
    endtask

    task automatic pop_one();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic check_char(input string req, input logic [7:0] d, input bit ep, input bit ef, input bit eb);
        @(negedge clk);
        chk(req, "ready", rx_ready, 1);
        chk(req, "data", rx_data, d);
        chk(req, "parity flag", err_parity, ep);
        chk(req, "frame flag", err_frame, ef);
        chk(req, "break flag", err_break, eb);
        pop_one();
    endtask

    task automatic check_empty(input string req);
        @(negedge clk);
        chk(req, "queue empty", rx_ready, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11", "ready after reset", rx_ready, 0);
        chk("R11", "parity after reset", err_parity, 0);
        chk("R11", "frame after reset", err_frame, 0);
        chk("R11", "break after reset", err_break, 0);
        chk("R11", "overrun after reset", err_overrun, 0);
    endtask

    task automatic t_lengths();
        line_ctl = 6'b000011;
        send_frame(8'hA5, 8, 0, 0, 1);
        check_char("R1 R3 8-bit", 8'hA5, 0, 0, 0);
        line_ctl = 6'b000010;
        send_frame(8'h5A, 7, 0, 0, 1);
        check_char("R1 7-bit", 8'h5A, 0, 0, 0);
        line_ctl = 6'b000001;
        send_frame(8'hED, 6, 0, 0, 1);
        check_char("R1 6-bit upper zero", 8'h2D, 0, 0, 0);
        line_ctl = 6'b000000;
        send_frame(8'h13, 5, 0, 0, 1);
        check_char("R1 R3 5-bit", 8'h13, 0, 0, 0);
        check_empty("R1");
    endtask

    task automatic t_glitch();
        line_ctl = 6'b000011;
        wait_ticks(1);
        @(negedge clk) rxd = 1'b0;
        wait_ticks(4);
        @(negedge clk) rxd = 1'b1;
        wait_ticks(48);
        check_empty("R2 short low pulse");
        send_frame(8'h3E, 8, 0, 0, 1);
        check_char("R2 frame after glitch", 8'h3E, 0, 0, 0);
        check_empty("R2");
    endtask

    task automatic t_parity();
        for (int m = 0; m < 4; m++) begin
            logic [1:0] mode = 2'(m);
            logic       good = calc_par(mode, 8'h13);
            line_ctl = {mode, 1'b1, 1'b0, 2'b00};
            send_frame(8'h13, 5, 1, good, 1);
            check_char("R4 parity match", 8'h13, 0, 0, 0);
            send_frame(8'h13, 5, 1, ~good, 1);
            check_char("R4 parity mismatch", 8'h13, 1, 0, 0);
        end
        line_ctl = 6'b011011;
        send_frame(8'hC6, 8, 1, calc_par(2'b01, 8'hC6), 1);
        check_char("R4 even 8-bit", 8'hC6, 0, 0, 0);
    endtask

    task automatic t_stop_sel();
        line_ctl = 6'b000111;
        send_frame(8'h3C, 8, 0, 0, 1);
        check_char("R5 two-stop select", 8'h3C, 0, 0, 0);
        line_ctl = 6'b000011;
        send_frame(8'h3C, 8, 0, 0, 1);
        check_char("R5 one-stop select", 8'h3C, 0, 0, 0);
    endtask

    task automatic t_framing();
        line_ctl = 6'b000011;
        send_frame(8'h81, 8, 0, 0, 0);
        check_char("R6 stop low", 8'h81, 0, 1, 0);
        check_empty("R6 no extra char");
        line_ctl = 6'b000111;
        send_frame(8'h40, 8, 0, 0, 0);
        check_char("R6 stop low two-stop select", 8'h40, 0, 1, 0);
    endtask

    task automatic t_break();
        line_ctl = 6'b011011;
        wait_ticks(1);
        @(negedge clk) rxd = 1'b0;
        wait_ticks(16 * 14);
        @(negedge clk);
        chk("R7", "one char during break", rx_ready, 1);
        @(negedge clk) rxd = 1'b1;
        wait_ticks(32);
        check_char("R7 break char", 8'h00, 0, 0, 1);
        check_empty("R7 single break char");
        line_ctl = 6'b000011;
        send_frame(8'h77, 8, 0, 0, 1);
        check_char("R7 frame after break", 8'h77, 0, 0, 0);
    endtask

    task automatic t_overrun();
        line_ctl = 6'b000011;
        for (int i = 0; i < 17; i++) send_frame(8'(i * 7 + 1), 8, 0, 0, 1);
        @(negedge clk);
        chk("R9", "overrun set", err_overrun, 1);
        for (int i = 0; i < 16; i++) begin
            check_char("R8 R9 queued order", 8'(i * 7 + 1), 0, 0, 0);
            if (i == 0) begin
                @(negedge clk);
                chk("R9", "overrun cleared by read", err_overrun, 0);
            end
        end
        check_empty("R9 dropped char absent");
    endtask

    task automatic t_collide();
        line_ctl = 6'b000011;
        for (int i = 0; i < 16; i++) send_frame(8'(i * 11 + 3), 8, 0, 0, 1);
        fork
            send_frame(8'hEE, 8, 0, 0, 1);
            begin
                @(negedge rxd);
                wait_ticks(152);
                @(posedge baud_tick);
                rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0;
            end
        join
        @(negedge clk);
        chk("R10", "no overrun on read plus write", err_overrun, 0);
        for (int i = 1; i < 16; i++) check_char("R10 shifted order", 8'(i * 11 + 3), 0, 0, 0);
        check_char("R10 last written char", 8'hEE, 0, 0, 0);
        check_empty("R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lengths();
        t_glitch();
        t_parity();
        t_stop_sel();
        t_framing();
        t_break();
        t_overrun();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule